// File: doc/BRIEF.md
# Accumulating Multiply Execution Unit

This unit sits beside the integer pipeline of a 32-bit RISC-V core. It keeps a private accumulator, twice the register width, that the architectural register file cannot see. The core hands it every decoded instruction word together with the two source operand values and a valid strobe. The unit acts on instructions whose major opcode falls in the first custom opcode space. Every other instruction passes through with no effect.

Within that opcode, the 3-bit function field and the 7-bit function field choose the operation. The unit can zero the accumulator, return either half of it to a destination register, or multiply the two operands and add the product into the accumulator. The multiply-add comes in a narrow form and a wide form, and each form has a signed and an unsigned variant. The narrow form keeps only the low word of the product and the low word of the sum, and it clears the upper half. The wide form adds the full double-width product and wraps. A function-field combination that matches no operation raises a one-cycle illegal flag.

Results are registered. The write enable, destination index, result word and illegal flag all appear in the cycle after the valid strobe. The accumulator updates on the same edge, so an instruction issued in the next cycle already sees the new value.

Top module: `acc_mac_unit`

## Requirements
- R1: Only instructions with instr[6:0] = 7'b0001011 act. Any other opcode raises neither out_wr_en nor out_illegal and leaves the accumulator unchanged.
- R2: funct3 = instr[14:12] = 0 with funct7 = instr[31:25] = 0 sets the accumulator to zero.
- R3: funct3 = 0 with funct7 = 1 returns accumulator bits [31:0], and funct7 = 2 returns bits [63:32]. Either read drives out_result and raises out_wr_en, with out_rd = instr[11:7], one cycle after the valid strobe.
- R4: A read whose destination field instr[11:7] is 0 does not raise out_wr_en.
- R5: funct3 = 1 with funct7 = 0 (unsigned) or 1 (signed) adds the low 32 bits of opa*opb to accumulator bits [31:0], modulo 2^32. The sum is written to the accumulator zero-extended, so bits [63:32] become 0.
- R6: funct3 = 2 with funct7 = 0 adds the unsigned 64-bit product opa*opb to the accumulator, modulo 2^64.
- R7: funct3 = 2 with funct7 = 1 treats both operands as two's complement and adds the 64-bit signed product to the accumulator, modulo 2^64.
- R8: Clear and multiply-add instructions never raise out_wr_en.
- R9: Synchronous reset sets the accumulator to zero and drives out_wr_en, out_illegal, out_rd and out_result to zero.
- R10: Any other funct3/funct7 combination under the opcode raises out_illegal for one cycle, one cycle after the valid strobe, and leaves the accumulator unchanged.
- R11: A read issued in the cycle right after a multiply-add or clear returns the updated accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_instr | input | 32 | Decoded instruction word |
| in_opa | input | XLEN | First source operand value |
| in_opb | input | XLEN | Second source operand value |
| out_result | output | XLEN | Accumulator half returned by a read |
| out_wr_en | output | 1 | Register write enable for out_rd |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Unrecognised function combination under the opcode |

## Verification
The bench builds the unit with XLEN = 32 and the shared-multiplier variant, which is the default. With a 32-bit operand width, the bench can apply operands such as 0xFFFFFFFF and 0x80000000, so 64-bit wrap-around, the sign-extension corner of the most negative operand, and the narrow-mode carry drop can all be checked against hand-computed values. Because the shared multiplier serves both the signed and unsigned variants, alternating between them in the vector table exercises the operand-extension selection in both directions.

// File: rtl/acc_mac_pkg.sv
package acc_mac_pkg;

   localparam logic [6:0] ACC_MAC_OPCODE = 7'b0001011;

   typedef enum logic [2:0] {
      MOP_NONE,
      MOP_CLEAR,
      MOP_RD_LO,
      MOP_RD_HI,
      MOP_MAC_NARROW,
      MOP_MAC_WIDE,
      MOP_ILLEGAL
   } mac_op_e;

endpackage

// File: rtl/acc_mac_decode.sv
module acc_mac_decode
   import acc_mac_pkg::*;
#(
   parameter logic [6:0] OPCODE = ACC_MAC_OPCODE
) (
   input  logic       valid,
   input  logic [6:0] opc,
   input  logic [2:0] fn3,
   input  logic [6:0] fn7,
   output mac_op_e    op,
   output logic       is_signed
);

   logic hit;
   assign hit = valid && (opc == OPCODE);

   always_comb begin
      op        = MOP_NONE;
      is_signed = 1'b0;
      if (hit) begin
         op = MOP_ILLEGAL;
         unique case (fn3)
            3'd0: begin
               if (fn7 == 7'd0)      op = MOP_CLEAR;
               else if (fn7 == 7'd1) op = MOP_RD_LO;
               else if (fn7 == 7'd2) op = MOP_RD_HI;
            end
            3'd1: begin
               if (fn7 <= 7'd1) begin
                  op        = MOP_MAC_NARROW;
                  is_signed = fn7[0];
               end
            end
            3'd2: begin
               if (fn7 <= 7'd1) begin
                  op        = MOP_MAC_WIDE;
                  is_signed = fn7[0];
               end
            end
            default: op = MOP_ILLEGAL;
         endcase
      end
   end

endmodule

// File: rtl/acc_mac_mult.sv
module acc_mac_mult #(
   parameter int XLEN        = 32,
   parameter bit SHARED_MULT = 1'b1,
   localparam int PW         = 2 * XLEN
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            is_signed,
   output logic [PW-1:0]   prod
);

   if (SHARED_MULT) begin : g_shared
      logic signed [XLEN:0] ext_a, ext_b;
      logic signed [PW-1:0] p_s;
      assign ext_a = {is_signed & a[XLEN-1], a};
      assign ext_b = {is_signed & b[XLEN-1], b};
      assign p_s   = ext_a * ext_b;
      assign prod  = p_s;
   end else begin : g_split
      logic        [PW-1:0] p_u;
      logic signed [PW-1:0] p_s;
      assign p_u  = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
      assign p_s  = $signed(a) * $signed(b);
      assign prod = is_signed ? p_s : p_u;
   end

endmodule

// File: rtl/acc_mac_accum.sv
module acc_mac_accum
   import acc_mac_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int AW  = 2 * XLEN
) (
   input  logic          clk,
   input  logic          rst,
   input  mac_op_e       op,
   input  logic [AW-1:0] prod,
   output logic [AW-1:0] acc
);

   logic [AW-1:0]   acc_nxt;
   logic [XLEN-1:0] low_sum;

   assign low_sum = acc[XLEN-1:0] + prod[XLEN-1:0];

   always_comb begin
      acc_nxt = acc;
      case (op)
         MOP_CLEAR:      acc_nxt = '0;
         MOP_MAC_NARROW: acc_nxt = {{XLEN{1'b0}}, low_sum};
         MOP_MAC_WIDE:   acc_nxt = acc + prod;
         default:        acc_nxt = acc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc_nxt;
   end

endmodule

// File: rtl/acc_mac_unit.sv
module acc_mac_unit
   import acc_mac_pkg::*;
#(
   parameter int         XLEN        = 32,
   parameter bit         SHARED_MULT = 1'b1,
   parameter logic [6:0] OPCODE      = ACC_MAC_OPCODE,
   localparam int        AW          = 2 * XLEN
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [31:0]     in_instr,
   input  logic [XLEN-1:0] in_opa,
   input  logic [XLEN-1:0] in_opb,
   output logic [XLEN-1:0] out_result,
   output logic            out_wr_en,
   output logic [4:0]      out_rd,
   output logic            out_illegal
);

   if (XLEN < 8 || (XLEN % 8) != 0) begin : g_bad_xlen
      $error("acc_mac_unit: XLEN must be a multiple of 8, at least 8");
   end
   if (OPCODE[1:0] != 2'b11) begin : g_bad_opcode
      $error("acc_mac_unit: OPCODE must have its two low bits set");
   end

   mac_op_e       op;
   logic          is_signed;
   logic [AW-1:0] prod;
   logic [AW-1:0] acc_q;
   logic          is_read;
   logic [4:0]    rd_fld;
   logic          unused_rs_fields;

   assign rd_fld           = in_instr[11:7];
   assign unused_rs_fields = ^in_instr[24:15];

   acc_mac_decode #(.OPCODE(OPCODE)) u_dec (
      .valid     (in_valid),
      .opc       (in_instr[6:0]),
      .fn3       (in_instr[14:12]),
      .fn7       (in_instr[31:25]),
      .op        (op),
      .is_signed (is_signed)
   );

   acc_mac_mult #(.XLEN(XLEN), .SHARED_MULT(SHARED_MULT)) u_mul (
      .a         (in_opa),
      .b         (in_opb),
      .is_signed (is_signed),
      .prod      (prod)
   );

   acc_mac_accum #(.XLEN(XLEN)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .op   (op),
      .prod (prod),
      .acc  (acc_q)
   );

   assign is_read = (op == MOP_RD_LO) || (op == MOP_RD_HI);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_result  <= '0;
         out_wr_en   <= 1'b0;
         out_rd      <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_wr_en   <= is_read && (rd_fld != 5'd0);
         out_illegal <= (op == MOP_ILLEGAL);
         if (is_read) begin
            out_rd     <= rd_fld;
            out_result <= (op == MOP_RD_HI) ? acc_q[AW-1:XLEN] : acc_q[XLEN-1:0];
         end
      end
   end

endmodule

// File: rtl/acc_mac_checker.sv
module acc_mac_checker #(
   parameter int         XLEN   = 32,
   parameter logic [6:0] OPCODE = 7'b0001011,
   localparam int        AW     = 2 * XLEN
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [6:0]    opc,
   input logic [2:0]    fn3,
   input logic [6:0]    fn7,
   input logic [4:0]    rd_fld,
   input logic [AW-1:0] acc_q,
   input logic          out_wr_en,
   input logic [4:0]    out_rd,
   input logic          out_illegal
);

   logic mine, rd_req, clr_req, narrow_req, known;
   assign mine       = in_valid && (opc == OPCODE);
   assign rd_req     = mine && (fn3 == 3'd0) && (fn7 == 7'd1 || fn7 == 7'd2);
   assign clr_req    = mine && (fn3 == 3'd0) && (fn7 == 7'd0);
   assign narrow_req = mine && (fn3 == 3'd1) && (fn7 <= 7'd1);
   assign known      = rd_req || clr_req || narrow_req ||
                       (mine && (fn3 == 3'd2) && (fn7 <= 7'd1));

   // R1: foreign opcodes have no effect
   p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opc != OPCODE) |=> (!out_wr_en && !out_illegal && $stable(acc_q)));

   // R2: clear zeroes the accumulator
   p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
      clr_req |=> (acc_q == '0));

   // R3: a read with nonzero rd writes that rd
   p_read_writes_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_fld != 5'd0) |=> (out_wr_en && out_rd == $past(rd_fld)));

   // R4: a write never targets register 0
   p_no_x0_write_r4: assert property (@(posedge clk) disable iff (rst)
      out_wr_en |-> (out_rd != 5'd0));

   // R5: narrow accumulate clears the upper half
   p_narrow_upper_r5: assert property (@(posedge clk) disable iff (rst)
      narrow_req |=> (acc_q[AW-1:XLEN] == '0));

   // R8: write enable only follows a read
   p_wr_from_read_r8: assert property (@(posedge clk) disable iff (rst)
      out_wr_en |-> $past(rd_req));

   // R10: unrecognised combination flags and holds state
   p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (mine && !known) |=> (out_illegal && !out_wr_en && $stable(acc_q)));

   // R10: flag only after an unrecognised combination
   p_illegal_cause_r10: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> $past(mine && !known));

endmodule

bind acc_mac_unit acc_mac_checker #(.XLEN(XLEN), .OPCODE(OPCODE)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .opc         (in_instr[6:0]),
   .fn3         (in_instr[14:12]),
   .fn7         (in_instr[31:25]),
   .rd_fld      (in_instr[11:7]),
   .acc_q       (acc_q),
   .out_wr_en   (out_wr_en),
   .out_rd      (out_rd),
   .out_illegal (out_illegal)
);

// File: tb/test_acc_mac_unit.sv
module test_acc_mac_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] OPC = 7'b0001011;

   typedef struct packed {
      logic [6:0]  f7;
      logic [2:0]  f3;
      logic [31:0] a;
      logic [31:0] b;
      logic [63:0] exp_acc;
      logic        exp_ill;
   } vec_t;

   // clear, wide unsigned, wide signed, narrow, illegal, clear
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{7'd0, 3'd0, 32'h0,        32'h0,        64'h0,                  1'b0},
      '{7'd0, 3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFE_00000001, 1'b0},
      '{7'd0, 3'd2, 32'h2,        32'h80000000, 64'hFFFFFFFF_00000001, 1'b0},
      '{7'd0, 3'd2, 32'hFFFFFFFF, 32'h1,        64'h0,                  1'b0},
      '{7'd1, 3'd2, 32'hFFFFFFFF, 32'h5,        64'hFFFFFFFF_FFFFFFFB, 1'b0},
      '{7'd1, 3'd2, 32'h80000000, 32'h80000000, 64'h3FFFFFFF_FFFFFFFB, 1'b0},
      '{7'd1, 3'd2, 32'h3,        32'h2,        64'h40000000_00000001, 1'b0},
      '{7'd0, 3'd1, 32'h00010000, 32'h00010000, 64'h00000000_00000001, 1'b0},
      '{7'd1, 3'd1, 32'hFFFFFFFF, 32'h2,        64'h00000000_FFFFFFFF, 1'b0},
      '{7'd0, 3'd1, 32'h1,        32'h1,        64'h0,                  1'b0},
      '{7'd0, 3'd2, 32'h12345678, 32'h10,       64'h00000001_23456780, 1'b0},
      '{7'd3, 3'd0, 32'h7,        32'h7,        64'h00000001_23456780, 1'b1},
      '{7'd1, 3'd1, 32'hFFFFFFFE, 32'hFFFFFFFD, 64'h00000000_23456786, 1'b0},
      '{7'd0, 3'd0, 32'h5,        32'h5,        64'h0,                  1'b0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [31:0] in_opa = '0;
   logic [31:0] in_opb = '0;
   logic [31:0] out_result;
   logic        out_wr_en;
   logic [4:0]  out_rd;
   logic        out_illegal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   acc_mac_unit i_acc_mac_unit (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_instr (in_instr),
      .in_opa (in_opa), .in_opb (in_opb), .out_result (out_result),
      .out_wr_en (out_wr_en), .out_rd (out_rd), .out_illegal (out_illegal)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, return at the next one with outputs settled
   task automatic issue(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd,
                        input logic [31:0] a, input logic [31:0] b, input logic [6:0] opc);
      in_valid = 1'b1;
      in_instr = {f7, 10'd0, f3, rd, opc};
      in_opa   = a;
      in_opb   = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_instr = '0;
   endtask

   task automatic read_back(input string req, input logic [63:0] exp);
      issue(7'd1, 3'd0, 5'd5, 32'h0, 32'h0, OPC);
      check({req, " lo"}, out_result, exp[31:0]);
      check({req, " lo wr"}, {out_wr_en, out_rd}, {1'b1, 5'd5});
      issue(7'd2, 3'd0, 5'd6, 32'h0, 32'h0, OPC);
      check({req, " hi"}, out_result, exp[63:32]);
      check({req, " hi wr"}, {out_wr_en, out_rd}, {1'b1, 5'd6});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: reset state
      check("R9 outputs", {out_result, out_wr_en, out_rd, out_illegal}, '0);
      read_back("R9 acc", 64'h0);

      // vector table, read issued right after each op (R11)
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].f7, VECS[i].f3, 5'd0, VECS[i].a, VECS[i].b, OPC);
         check($sformatf("R10 illegal v%0d", i), out_illegal, VECS[i].exp_ill);
         check($sformatf("R8 no wr v%0d", i), out_wr_en, 1'b0);
         read_back($sformatf("R11 R2 R5 R6 R7 v%0d", i), VECS[i].exp_acc);
      end

      // R8: accumulate with a nonzero rd field still writes nothing
      issue(7'd0, 3'd2, 5'd9, 32'h3, 32'h4, OPC);
      check("R8 mac rd!=0", out_wr_en, 1'b0);
      read_back("R6 after rd mac", 64'hC);

      // R4: read to register 0
      issue(7'd1, 3'd0, 5'd0, 32'h0, 32'h0, OPC);
      check("R4 rd0 lo", out_wr_en, 1'b0);
      issue(7'd2, 3'd0, 5'd0, 32'h0, 32'h0, OPC);
      check("R4 rd0 hi", out_wr_en, 1'b0);

      // R1: same fields under a foreign opcode
      issue(7'd0, 3'd2, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 7'b0110011);
      check("R1 foreign", {out_wr_en, out_illegal}, 2'b00);
      issue(7'd0, 3'd0, 5'd3, 32'h0, 32'h0, 7'b0101011);
      check("R1 foreign clear", {out_wr_en, out_illegal}, 2'b00);
      read_back("R1 acc kept", 64'hC);

      // R10: more unrecognised combinations
      issue(7'd2, 3'd1, 5'd4, 32'h1, 32'h1, OPC);
      check("R10 f3=1 f7=2", out_illegal, 1'b1);
      issue(7'd0, 3'd7, 5'd4, 32'h1, 32'h1, OPC);
      check("R10 f3=7", out_illegal, 1'b1);
      read_back("R10 acc kept", 64'hC);

      // R5: narrow wrap clears a nonzero upper half
      issue(7'd0, 3'd2, 5'd0, 32'h80000000, 32'h4, OPC);
      issue(7'd0, 3'd1, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, OPC);
      read_back("R5 upper cleared", 64'h0000000D);

      // R9: reset in the middle of use
      issue(7'd1, 3'd2, 5'd0, 32'hFFFFFFFF, 32'h7, OPC);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9 mid reset outputs", {out_result, out_wr_en, out_rd, out_illegal}, '0);
      read_back("R9 mid reset acc", 64'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule